// File: doc/BRIEF.md
# Four-Channel Descriptor-Chained DMA Controller

This block copies bytes from one address range to another over a single word-wide memory port. Four channels share one transfer engine. Software starts a channel with one register write that points at a descriptor in memory. The descriptor gives a source, a destination and a shape: a piece length in bytes, a piece count, and a source stride and a destination stride added to each piece's start address after the piece is copied. A link word then either ends the work or names the next descriptor. Source and destination may sit at any byte address. Each byte is read from its containing word and written back with a single byte enable.

A channel can instead be paced from outside. It then waits for its request input before each descriptor, pulses its acknowledge output when the engine takes it, and pulses its done output when that descriptor retires. Ready channels are served in rotating order, one whole descriptor at a time. Each channel keeps five sticky status bits with matching enable bits, and one interrupt line that is the OR of the enabled bits.

The memory port is a valid/ready request channel with a response channel that has no back-pressure. A request, with its address, write flag, data and byte enables, stays unchanged until the cycle in which ready is high. Only one request is in flight at a time. Its response may come in any later cycle and is taken in the cycle it arrives.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset, every channel is idle (`busy` low), all status bits and `irq` are low, `dack`/`ddone` are low and no memory request is presented.
- R2: A register write with `reg_sel`=0 to an idle channel whose error bit is clear starts it at descriptor address `reg_wdata` with bits 1:0 forced to zero; `reg_wdata` bit 0 = 1 selects paced mode. The same write to a busy channel, or to a channel whose error bit is set, is ignored.
- R3: A descriptor is five little-endian words at byte offsets +0 source, +4 destination, +8 {piece count[31:16], piece length[15:0]}, +12 {destination stride[31:16], source stride[15:0]}, +16 link. Bytes are copied one at a time from any byte address, and each write to a word enables only the lane (address bits 1:0) of the byte it carries.
- R4: Piece p, byte b goes from source start + p×source stride + b to destination start + p×destination stride + b. Bytes between pieces are left untouched.
- R5: Status bit positions per channel: bit 0 segment, bit 1 link, bit 2 list, bit 3 chain, bit 4 error. Every retired descriptor sets the segment bit. A link word with a non-zero address (bits 31:2) and bit 0 clear also sets the link bit, and the channel goes on to that address.
- R6: A link word with bit 0 (end of list) set sets the list bit. If its address is non-zero the channel then goes on to it. A zero link address sets the list and chain bits and returns the channel to idle.
- R7: In paced mode the channel waits, with no memory traffic, until its `dreq` bit is high before each descriptor. `dack` pulses for one cycle when the engine takes that descriptor and `ddone` pulses for one cycle when it retires.
- R8: Ready channels are served in rotating order, starting after the last channel served, one whole descriptor per turn.
- R9: An error response aborts the channel at once, sets only its error bit and drops `busy`. Start writes are ignored until the error bit is cleared.
- R10: `reg_sel`=1 clears the status bits set in `reg_wdata[4:0]`, and a bit being set in the same cycle wins. `reg_sel`=2 loads the enable bits. `irq` for a channel is high when any status bit and its enable bit are both set.
- R11: Once a request is presented it holds address, write flag and byte enables until accepted. No new request is presented while a response is outstanding.
- R12: A descriptor with piece length 0 or piece count 0 moves no data and still retires with its segment, list and chain bits as given by its link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel addressed by the write |
| reg_sel | input | 2 | 0 start, 1 clear status, 2 enable, 3 no effect |
| reg_wdata | input | 32 | Write data |
| dreq | input | 4 | External request per channel (paced mode) |
| dack | output | 4 | One-cycle pulse when a paced descriptor is taken |
| ddone | output | 4 | One-cycle pulse when a paced descriptor retires |
| busy | output | 4 | Channel has work in progress |
| irq | output | 4 | Interrupt per channel |
| status | output | 20 | Five status bits per channel, channel c at bits 5c+4:5c |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory accepts request |
| mreq_we | output | 1 | 1 write, 0 read |
| mreq_addr | output | 32 | Word-aligned byte address |
| mreq_wdata | output | 32 | Write data (byte copied to all lanes) |
| mreq_be | output | 4 | Byte enables for writes |
| mrsp_valid | input | 1 | Response valid for the outstanding request |
| mrsp_rdata | input | 32 | Read data |
| mrsp_err | input | 1 | Response carries an error |

## Verification
The assertions assume that the memory answers only when a request is outstanding and never sends two responses for one request. They also assume that `reg_ch` names an existing channel. The bench's memory model queues a single response one cycle after each accepted request and drops ready at pseudo-random times, so the hold rule on requests is exercised while those assumptions stay true. Register writes come only from a task that drives a valid channel number on the falling edge.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int NSTAT     = 5;
  localparam int BIT_SEG   = 0;
  localparam int BIT_LINK  = 1;
  localparam int BIT_LIST  = 2;
  localparam int BIT_CHAIN = 3;
  localparam int BIT_ERR   = 4;

  typedef enum logic [2:0] {S_IDLE, S_DESC, S_RD, S_WR, S_RET} eng_st_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs import dma_pkg::*; #(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_start,
  input  logic             wr_clr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wdata,
  input  logic             ev_hit,
  input  logic [NSTAT-1:0] ev_bits,
  input  logic             ev_cont,
  input  logic [AW-1:0]    ev_next,
  output logic             armed,
  output logic             paced,
  output logic [AW-1:0]    ptr,
  output logic [NSTAT-1:0] stat,
  output logic             irq
);
  logic [NSTAT-1:0] en;
  logic [NSTAT-1:0] clr_mask, set_mask;

  assign clr_mask = wr_clr ? wdata[NSTAT-1:0] : '0;
  assign set_mask = ev_hit ? ev_bits : '0;
  assign irq = |(stat & en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      paced <= 1'b0;
      ptr   <= '0;
      stat  <= '0;
      en    <= '0;
    end else begin
      if (ev_hit) begin
        if (ev_cont) ptr <= ev_next;
        else armed <= 1'b0;
      end else if (wr_start && !armed && !stat[BIT_ERR]) begin
        armed <= 1'b1;
        paced <= wdata[0];
        ptr   <= {wdata[AW-1:2], 2'b00};
      end
      stat <= (stat & ~clr_mask) | set_mask;
      if (wr_en) en <= wdata[NSTAT-1:0];
    end
  end

  // R9: a halted channel does not accept a start
  p_halt_blocks_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && !armed && stat[BIT_ERR] && !wr_clr) |=> !armed);
  // R2: a clean idle channel arms on a start write
  p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && !armed && !stat[BIT_ERR] && !ev_hit) |=> armed);
  // R9: an error event halts the channel with its error bit set
  p_err_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && ev_bits[BIT_ERR]) |=> (!armed && stat[BIT_ERR]));
endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           take,
  output logic           gnt_valid,
  output logic [CW-1:0]  gnt_idx
);
  logic [CW-1:0] last;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = 1; k <= NCH; k++) begin
      int j;
      j = (int'(last) + k) % NCH;
      if (!gnt_valid && req[j]) begin
        gnt_valid = 1'b1;
        gnt_idx   = CW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last <= CW'(NCH - 1);
    else if (take) last <= gnt_idx;
  end

  // R8: the engine only takes a channel that is requesting
  p_take_has_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (gnt_valid && req[gnt_idx]));
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine import dma_pkg::*; #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gnt_valid,
  input  logic [CW-1:0]    gnt_idx,
  input  logic [AW-1:0]    gnt_ptr,
  input  logic             gnt_paced,
  output logic             take,
  output logic             ev_valid,
  output logic [CW-1:0]    ev_ch,
  output logic [NSTAT-1:0] ev_bits,
  output logic             ev_cont,
  output logic [AW-1:0]    ev_next,
  output logic             done_pulse,
  output logic             mreq_valid,
  input  logic             mreq_ready,
  output logic             mreq_we,
  output logic [AW-1:0]    mreq_addr,
  output logic [31:0]      mreq_wdata,
  output logic [3:0]       mreq_be,
  input  logic             mrsp_valid,
  input  logic [31:0]      mrsp_rdata,
  input  logic             mrsp_err
);
  eng_st_t       st;
  logic          wait_rsp, paced_q;
  logic [2:0]    widx;
  logic [CW-1:0] ch;
  logic [AW-1:0] dptr, sbase, dbase, link;
  logic [15:0]   plen, pcnt, sstr, dstr, bcnt, pidx;
  logic [7:0]    byte_q, rd_byte;
  logic [AW-1:0] cur_s, cur_d, lnk_addr;
  logic          rsp_ok, rsp_bad, lnk_zero;

  assign cur_s    = sbase + AW'(bcnt);
  assign cur_d    = dbase + AW'(bcnt);
  assign lnk_addr = {link[AW-1:2], 2'b00};
  assign lnk_zero = (lnk_addr == '0);
  assign rsp_ok   = wait_rsp && mrsp_valid && !mrsp_err;
  assign rsp_bad  = wait_rsp && mrsp_valid && mrsp_err;
  assign rd_byte  = 8'(mrsp_rdata >> {cur_s[1:0], 3'b000});

  assign take       = (st == S_IDLE) && gnt_valid;
  assign mreq_valid = (st == S_DESC || st == S_RD || st == S_WR) && !wait_rsp;
  assign mreq_we    = (st == S_WR);
  assign mreq_wdata = {4{byte_q}};
  assign mreq_be    = 4'b0001 << cur_d[1:0];

  always_comb begin
    case (st)
      S_DESC:  mreq_addr = dptr + AW'({widx, 2'b00});
      S_RD:    mreq_addr = {cur_s[AW-1:2], 2'b00};
      default: mreq_addr = {cur_d[AW-1:2], 2'b00};
    endcase
  end

  always_comb begin
    ev_bits = '0;
    if (rsp_bad) begin
      ev_bits[BIT_ERR] = 1'b1;
    end else begin
      ev_bits[BIT_SEG]   = 1'b1;
      ev_bits[BIT_LINK]  = !lnk_zero && !link[0];
      ev_bits[BIT_LIST]  = lnk_zero || link[0];
      ev_bits[BIT_CHAIN] = lnk_zero;
    end
  end

  assign ev_valid   = (st == S_RET) || rsp_bad;
  assign ev_ch      = ch;
  assign ev_cont    = (st == S_RET) && !lnk_zero;
  assign ev_next    = lnk_addr;
  assign done_pulse = (st == S_RET) && paced_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wait_rsp <= 1'b0; paced_q <= 1'b0; widx <= '0; ch <= '0;
      dptr <= '0; sbase <= '0; dbase <= '0; link <= '0; byte_q <= '0;
      plen <= '0; pcnt <= '0; sstr <= '0; dstr <= '0; bcnt <= '0; pidx <= '0;
    end else begin
      if (mreq_valid && mreq_ready) wait_rsp <= 1'b1;
      if (wait_rsp && mrsp_valid) wait_rsp <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          ch <= gnt_idx; paced_q <= gnt_paced; dptr <= gnt_ptr;
          widx <= '0; st <= S_DESC;
        end
        S_RET: st <= S_IDLE;
        default: if (rsp_bad) begin
          st <= S_IDLE;
        end else if (rsp_ok) begin
          case (st)
            S_DESC: begin
              case (widx)
                3'd0:    sbase <= AW'(mrsp_rdata);
                3'd1:    dbase <= AW'(mrsp_rdata);
                3'd2:    {pcnt, plen} <= mrsp_rdata;
                3'd3:    {dstr, sstr} <= mrsp_rdata;
                default: link <= AW'(mrsp_rdata);
              endcase
              widx <= widx + 3'd1;
              if (widx == 3'd4) begin
                bcnt <= '0; pidx <= '0;
                st <= (plen == '0 || pcnt == '0) ? S_RET : S_RD;
              end
            end
            S_RD: begin byte_q <= rd_byte; st <= S_WR; end
            default: begin
              if (bcnt == plen - 16'd1) begin
                bcnt  <= '0;
                sbase <= sbase + AW'(sstr);
                dbase <= dbase + AW'(dstr);
                if (pidx == pcnt - 16'd1) st <= S_RET;
                else begin pidx <= pidx + 16'd1; st <= S_RD; end
              end else begin
                bcnt <= bcnt + 16'd1; st <= S_RD;
              end
            end
          endcase
        end
      endcase
    end
  end

  // R11: a stalled request holds its fields until accepted
  p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)
      && $stable(mreq_we) && $stable(mreq_be)));
  // R11: an accepted request is followed by a quiet request channel
  p_one_flight_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_ready) |=> !mreq_valid);
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl import dma_pkg::*; #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [CW-1:0]      reg_ch,
  input  logic [1:0]         reg_sel,
  input  logic [AW-1:0]      reg_wdata,
  input  logic [NCH-1:0]     dreq,
  output logic [NCH-1:0]     dack,
  output logic [NCH-1:0]     ddone,
  output logic [NCH-1:0]     busy,
  output logic [NCH-1:0]     irq,
  output logic [NCH*NSTAT-1:0] status,
  output logic               mreq_valid,
  input  logic               mreq_ready,
  output logic               mreq_we,
  output logic [AW-1:0]      mreq_addr,
  output logic [31:0]        mreq_wdata,
  output logic [3:0]         mreq_be,
  input  logic               mrsp_valid,
  input  logic [31:0]        mrsp_rdata,
  input  logic               mrsp_err
);
  logic [NCH-1:0]   armed, paced, elig;
  logic [AW-1:0]    ptr_arr [NCH];
  logic             gnt_valid, take, ev_valid, ev_cont, done_pulse;
  logic [CW-1:0]    gnt_idx, ev_ch;
  logic [NSTAT-1:0] ev_bits;
  logic [AW-1:0]    ev_next;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_me;
    assign sel_me = reg_we && (reg_ch == CW'(i));
    dma_chan_regs #(.AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_start(sel_me && reg_sel == 2'd0),
      .wr_clr(sel_me && reg_sel == 2'd1),
      .wr_en(sel_me && reg_sel == 2'd2),
      .wdata(reg_wdata),
      .ev_hit(ev_valid && ev_ch == CW'(i)),
      .ev_bits(ev_bits), .ev_cont(ev_cont), .ev_next(ev_next),
      .armed(armed[i]), .paced(paced[i]), .ptr(ptr_arr[i]),
      .stat(status[i*NSTAT +: NSTAT]), .irq(irq[i])
    );
    assign elig[i]  = armed[i] && (!paced[i] || dreq[i]);
    assign dack[i]  = take && paced[i] && (gnt_idx == CW'(i));
    assign ddone[i] = done_pulse && (ev_ch == CW'(i));

    // R7: a paced channel is acknowledged only while it requests
    p_dack_needs_dreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dack[i] |-> dreq[i]);
  end

  assign busy = armed;

  dma_rr_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(elig), .take(take),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  dma_xfer_engine #(.NCH(NCH), .AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx),
    .gnt_ptr(ptr_arr[gnt_idx]), .gnt_paced(paced[gnt_idx]),
    .take(take), .ev_valid(ev_valid), .ev_ch(ev_ch), .ev_bits(ev_bits),
    .ev_cont(ev_cont), .ev_next(ev_next), .done_pulse(done_pulse),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_we(mreq_we),
    .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata), .mreq_be(mreq_be),
    .mrsp_valid(mrsp_valid), .mrsp_rdata(mrsp_rdata), .mrsp_err(mrsp_err)
  );

  // R7: at most one channel is acknowledged per cycle
  p_dack_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));
endmodule

// File: tb/dma_chain_ctrl_test.sv
`timescale 1ns/1ps
module dma_chain_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [1:0]  reg_ch = '0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack, ddone, busy, irq;
  logic [19:0] status;
  logic        mreq_valid, mreq_we, mreq_ready;
  logic [31:0] mreq_addr, mreq_wdata;
  logic [3:0]  mreq_be;
  logic        rsp_v = 1'b0, rsp_e = 1'b0;
  logic [31:0] rsp_d = '0;

  dma_chain_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dreq(dreq), .dack(dack), .ddone(ddone), .busy(busy),
    .irq(irq), .status(status), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
    .mreq_we(mreq_we), .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata),
    .mreq_be(mreq_be), .mrsp_valid(rsp_v), .mrsp_rdata(rsp_d), .mrsp_err(rsp_e)
  );

  // memory model: 256 words, error region from 0x3C0
  logic [31:0] mem [256];
  logic        poke_en = 1'b0;
  logic [31:0] poke_addr = '0, poke_data = '0;
  logic [7:0]  lf = 8'hA5;
  logic        outst = 1'b0, prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  int          viol = 0;
  int          log_n = 0;
  logic [31:0] log_a [8];
  int          dack3 = 0, ddone3 = 0;

  assign mreq_ready = lf[0] | lf[2];

  always @(posedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    if (poke_en) mem[poke_addr[9:2]] <= poke_data;
    if (rst_n) begin
      if (prev_stall && (!mreq_valid || mreq_addr != prev_addr)) viol <= viol + 1;
      if (mreq_valid && outst) viol <= viol + 1;
    end
    prev_stall <= mreq_valid && !mreq_ready;
    prev_addr  <= mreq_addr;
    if (rsp_v) outst <= 1'b0;
    rsp_v <= 1'b0;
    if (rst_n && mreq_valid && mreq_ready) begin
      outst <= 1'b1;
      rsp_v <= 1'b1;
      rsp_e <= (mreq_addr[9:0] >= 10'h3C0);
      rsp_d <= mem[mreq_addr[9:2]];
      if (mreq_we && mreq_addr[9:0] < 10'h3C0)
        for (int b = 0; b < 4; b++)
          if (mreq_be[b]) mem[mreq_addr[9:2]][8*b +: 8] <= mreq_wdata[8*b +: 8];
      if (!mreq_we && log_n < 8 && (mreq_addr == 32'h100 || mreq_addr == 32'h120 ||
          mreq_addr == 32'h140 || mreq_addr == 32'h160)) begin
        log_a[log_n] <= mreq_addr;
        log_n <= log_n + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (dack[3]) dack3 <= dack3 + 1;
    if (ddone[3]) ddone3 <= ddone3 + 1;
  end

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] srcb(input int a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [7:0] peekb(input int a);
    logic [7:0] w;
    w = 8'(a >> 2);
    return mem[w][8*(a & 3) +: 8];
  endfunction

  function automatic logic [4:0] st_of(input int c);
    return status[c*5 +: 5];
  endfunction

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = 32'(a); poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic put_desc(input int base, input int src, input int dst, input int len,
                          input int cnt, input int sstr, input int dstr, input int lnk);
    poke(base,      32'(src));
    poke(base + 4,  32'(dst));
    poke(base + 8,  {16'(cnt), 16'(len)});
    poke(base + 12, {16'(dstr), 16'(sstr)});
    poke(base + 16, 32'(lnk));
  endtask

  task automatic reg_wr(input int c, input int sel, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 2'(c); reg_sel = 2'(sel); reg_wdata = 32'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle(input int c);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (!busy[c]) return;
    end
  endtask

  task automatic t_reset;
    chk(busy == 4'h0 && irq == 4'h0, "R1", "busy/irq after reset", {busy, irq}, 0);
    chk(status == '0, "R1", "status after reset", int'(status), 0);
    chk(!mreq_valid && dack == 4'h0 && ddone == 4'h0, "R1", "no request/handshake",
        {mreq_valid, dack, ddone}, 0);
  endtask

  task automatic t_single;
    bit ok = 1'b1;
    put_desc(32'h000, 32'h201, 32'h302, 7, 1, 0, 0, 0);
    reg_wr(0, 0, 32'h000);
    chk(busy[0], "R2", "channel 0 busy after start", busy[0], 1);
    wait_idle(0);
    for (int i = 0; i < 7; i++) if (peekb(32'h302 + i) != srcb(32'h201 + i)) ok = 1'b0;
    chk(ok, "R3", "misaligned 7-byte copy", ok, 1);
    chk(peekb(32'h301) == 0 && peekb(32'h309) == 0, "R3", "lanes outside copy untouched",
        {peekb(32'h301), peekb(32'h309)}, 0);
    chk(st_of(0) == 5'h0D, "R6", "zero link sets seg/list/chain", st_of(0), 5'h0D);
  endtask

  task automatic t_irq;
    reg_wr(0, 2, 32'h0);
    chk(irq[0] == 1'b0, "R10", "irq low with no enable", irq[0], 0);
    reg_wr(0, 2, 32'h4);
    chk(irq[0] == 1'b1, "R10", "irq high with list enabled", irq[0], 1);
    reg_wr(0, 1, 32'h4);
    chk(st_of(0) == 5'h09 && irq[0] == 1'b0, "R10", "W1C clears only list bit",
        {st_of(0), irq[0]}, {5'h09, 1'b0});
    reg_wr(0, 2, 32'h0);
  endtask

  task automatic t_stride;
    bit ok = 1'b1;
    put_desc(32'h020, 32'h210, 32'h320, 2, 3, 5, 3, 0);
    reg_wr(1, 0, 32'h020);
    wait_idle(1);
    for (int p = 0; p < 3; p++)
      for (int b = 0; b < 2; b++)
        if (peekb(32'h320 + 3*p + b) != srcb(32'h210 + 5*p + b)) ok = 1'b0;
    chk(ok, "R4", "strided pieces copied", ok, 1);
    chk(peekb(32'h322) == 0 && peekb(32'h325) == 0 && peekb(32'h328) == 0, "R4",
        "gaps between pieces untouched", {peekb(32'h322), peekb(32'h325)}, 0);
  endtask

  task automatic t_link;
    reg_wr(2, 1, 32'h1F);
    put_desc(32'h060, 32'h230, 32'h340, 3, 1, 0, 0, 32'h080);
    put_desc(32'h080, 32'h238, 32'h348, 2, 1, 0, 0, 32'h0A1);
    put_desc(32'h0A0, 32'h240, 32'h350, 1, 1, 0, 0, 0);
    reg_wr(2, 0, 32'h060);
    wait_idle(2);
    chk(peekb(32'h342) == srcb(32'h232) && peekb(32'h349) == srcb(32'h239), "R5",
        "linked descriptors copied", peekb(32'h349), srcb(32'h239));
    chk(peekb(32'h350) == srcb(32'h240), "R6", "end-of-list with link continues",
        peekb(32'h350), srcb(32'h240));
    chk(st_of(2) == 5'h0F, "R5", "seg/link/list/chain all set", st_of(2), 5'h0F);
  endtask

  task automatic t_paced;
    bit quiet = 1'b1, ok = 1'b1;
    int d0, e0;
    put_desc(32'h0C0, 32'h250, 32'h358, 4, 1, 0, 0, 0);
    put_desc(32'h0E0, 32'h254, 32'h35E, 2, 1, 0, 0, 0);
    d0 = dack3; e0 = ddone3;
    reg_wr(3, 0, 32'h0C1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mreq_valid || !busy[3]) quiet = 1'b0;
    end
    chk(quiet && dack3 == d0, "R7", "paced channel idle without dreq", quiet, 1);
    reg_wr(3, 0, 32'h0E0);
    @(negedge clk);
    dreq[3] = 1'b1;
    wait_idle(3);
    dreq[3] = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) if (peekb(32'h358 + i) != srcb(32'h250 + i)) ok = 1'b0;
    chk(ok, "R7", "paced copy after dreq", ok, 1);
    chk(dack3 - d0 == 1 && ddone3 - e0 == 1, "R7", "one dack and one ddone pulse",
        {dack3 - d0, ddone3 - e0}, {32'd1, 32'd1});
    chk(peekb(32'h35E) == 0 && peekb(32'h35F) == 0, "R2", "start while busy ignored",
        peekb(32'h35E), 0);
  endtask

  task automatic t_rr;
    put_desc(32'h100, 32'h260, 32'h360, 2, 1, 0, 0, 32'h120);
    put_desc(32'h120, 32'h262, 32'h362, 2, 1, 0, 0, 0);
    put_desc(32'h140, 32'h264, 32'h364, 2, 1, 0, 0, 32'h160);
    put_desc(32'h160, 32'h266, 32'h366, 2, 1, 0, 0, 0);
    reg_wr(0, 0, 32'h100);
    reg_wr(1, 0, 32'h140);
    wait_idle(0);
    wait_idle(1);
    chk(log_n == 4 && log_a[0] == 32'h100 && log_a[1] == 32'h140 &&
        log_a[2] == 32'h120 && log_a[3] == 32'h160, "R8", "descriptor order alternates",
        log_n == 4 ? int'(log_a[1]) : log_n, 32'h140);
    chk(peekb(32'h367) == srcb(32'h267), "R8", "both chains complete",
        peekb(32'h367), srcb(32'h267));
  endtask

  task automatic t_zero;
    reg_wr(1, 1, 32'h1F);
    put_desc(32'h180, 32'h268, 32'h370, 0, 5, 1, 1, 0);
    reg_wr(1, 0, 32'h180);
    wait_idle(1);
    chk(peekb(32'h370) == 0 && peekb(32'h371) == 0, "R12", "zero length moves nothing",
        peekb(32'h370), 0);
    chk(st_of(1) == 5'h0D, "R12", "zero length still retires", st_of(1), 5'h0D);
  endtask

  task automatic t_err;
    reg_wr(0, 1, 32'h1F);
    reg_wr(0, 2, 32'h10);
    put_desc(32'h1A0, 32'h3C4, 32'h378, 2, 1, 0, 0, 0);
    put_desc(32'h1C0, 32'h26A, 32'h37C, 1, 1, 0, 0, 0);
    reg_wr(0, 0, 32'h1A0);
    wait_idle(0);
    chk(st_of(0) == 5'h10 && irq[0], "R9", "error bit only, irq raised",
        st_of(0), 5'h10);
    reg_wr(0, 0, 32'h1C0);
    repeat (20) @(negedge clk);
    chk(!busy[0] && peekb(32'h37C) == 0, "R9", "start ignored while halted",
        busy[0], 0);
    reg_wr(0, 1, 32'h10);
    chk(st_of(0) == 5'h00 && !irq[0], "R10", "error cleared by W1C", st_of(0), 0);
    reg_wr(0, 0, 32'h1C0);
    wait_idle(0);
    chk(peekb(32'h37C) == srcb(32'h26A) && st_of(0) == 5'h0D, "R9",
        "restart after clearing error", peekb(32'h37C), srcb(32'h26A));
  endtask

  initial begin
    for (int w = 0; w < 256; w++) mem[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int w = 32'h80; w < 32'hC0; w++)
      poke(4*w, {srcb(4*w+3), srcb(4*w+2), srcb(4*w+1), srcb(4*w)});
    t_single();
    t_irq();
    t_stride();
    t_link();
    t_paced();
    t_rr();
    t_zero();
    t_err();
    chk(viol == 0, "R11", "request hold / single outstanding", viol, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule